// File: doc/BRIEF.md
# Multi-Function I/O Configuration Port

This block is the configuration front end of a multi-function I/O controller. The host reaches it through a two-address window. Offset 0 is the index port and offset 1 is the data port. The host moves single bytes with a write strobe or a read strobe. After reset the configuration space is sealed. A fixed two-byte key written to the index port unseals it, and a single closing byte seals it again.

While the space is open, a write to the index port chooses a register number. The data port then reads or writes that register. One register picks a logical device, which switches in that device's private bank: an activate flag and an I/O base address. Two global controls sit outside the banks. One routes two shared pins to an I2C function. The other, held only in the power-management device's bank, sets how the system recovers after mains power is lost.

The decoded base addresses, activate flags and global controls leave the block as plain outputs for the functional units. The units themselves are outside this block.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the space is sealed (`cfg_open` = 0), the selected device is 0, every `dev_en` bit is 0, every base in `dev_base` is 0, `i2c_sel` is 0 and `pwr_mode` is 2'b00.
- R2: Two consecutive index-port writes of 8'h87 unseal the space, and `cfg_open` is 1 from the clock edge that takes the second write.
- R3: After a first 8'h87, any other write breaks the key and the sequence restarts. This covers an index-port write of another value and also any data-port write.
- R4: An index-port write of 8'hAA while open seals the space from the next edge.
- R5: While sealed, reads of either port return 8'hFF, and data-port writes change no state.
- R6: While open, an index-port write of any value except 8'hAA stores the register number, and an index-port read returns it. Data-port accesses act on that register.
- R7: Register 8'h07 holds the device number (low 4 bits kept; reads return it zero-extended). Registers 8'h30, 8'h60 and 8'h61 act on the bank of the selected device only. For a device number of 12 or more they read 8'h00 and ignore writes.
- R8: Register 8'h60 carries base bits 11:8 in data bits 3:0, and register 8'h61 carries base bits 7:0. Base bits 2:0 always read as 0. Bit 11 also reads as 0 for every device except device 8'h0B, so the largest base is 12'h7F8, or 12'hFF8 for device 8'h0B.
- R9: Bit 0 of register 8'h30 is the selected device's activate flag and drives its `dev_en` bit. The other bits read 0.
- R10: Bit 1 of global register 8'h2A drives `i2c_sel` and reads back in bit 1 with the other bits 0. It is reachable and unchanged whatever device is selected.
- R11: Register 8'h E4 exists only when device 8'h0A is selected. Its bits 6:5 drive `pwr_mode` (2'b01 = restore power after a failure) and the other bits read 0. With any other device selected it reads 8'h00 and ignores writes.
- R12: While open, any register number not listed above reads 8'h00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, 0 otherwise |
| cfg_open | output | 1 | Configuration space unsealed |
| dev_en | output | 12 | Activate flag per logical device |
| dev_base | output | 144 | 12-bit base address per device, device n in bits 12n+11:12n |
| i2c_sel | output | 1 | Shared pins routed to I2C |
| pwr_mode | output | 2 | Power-loss recovery selection |

## Verification
The assertions assume the host raises at most one of `bus_wr` and `bus_rd` in a cycle. They also assume reset is held low across at least one clock edge, so every register starts from a known value. The stimulus issues one strobe at a time, each followed by an idle cycle. It includes keys broken by index-port and data-port writes, writes into sealed and out-of-range banks, and all-ones base values that exercise the masking.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam logic [7:0] KEY_OPEN    = 8'h87;
   localparam logic [7:0] KEY_CLOSE   = 8'hAA;
   localparam logic [7:0] REG_DEVSEL  = 8'h07;
   localparam logic [7:0] REG_PINMUX  = 8'h2A;
   localparam logic [7:0] REG_ACTIVE  = 8'h30;
   localparam logic [7:0] REG_BASE_HI = 8'h60;
   localparam logic [7:0] REG_BASE_LO = 8'h61;
   localparam logic [7:0] REG_PWRLOSS = 8'hE4;

   typedef enum logic [1:0] {
      LK_SHUT = 2'd0,
      LK_HALF = 2'd1,
      LK_OPEN = 2'd2
   } lock_t;
endpackage

// File: rtl/cfgp_unlock.sv
module cfgp_unlock
   import cfgp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       dat_wr,
   input  logic [7:0] wdata,
   output logic       is_open,
   output logic [7:0] reg_idx
);
   lock_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= LK_SHUT;
         reg_idx <= 8'h00;
      end else begin
         case (st)
            LK_SHUT: begin
               if (idx_wr && wdata == KEY_OPEN) st <= LK_HALF;
            end
            LK_HALF: begin
               if (idx_wr)      st <= (wdata == KEY_OPEN) ? LK_OPEN : LK_SHUT;
               else if (dat_wr) st <= LK_SHUT;
            end
            LK_OPEN: begin
               if (idx_wr) begin
                  if (wdata == KEY_CLOSE) st <= LK_SHUT;
                  else                    reg_idx <= wdata;
               end
            end
            default: st <= LK_SHUT;
         endcase
      end
   end

   assign is_open = (st == LK_OPEN);
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank #(
   parameter int ADDR_W = 12,
   parameter int ALIGN  = 3,
   parameter bit WIDE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_we,
   input  logic              hi_we,
   input  logic              lo_we,
   input  logic [7:0]        wdata,
   output logic              active,
   output logic [ADDR_W-1:0] base
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << ALIGN;
   localparam logic [ADDR_W-1:0] TOP_MASK   = WIDE ? {ADDR_W{1'b1}} : ({ADDR_W{1'b1}} >> 1);
   localparam logic [ADDR_W-1:0] KEEP       = ALIGN_MASK & TOP_MASK;

   logic [ADDR_W-1:0] nxt;

   always_comb begin
      if (hi_we) nxt = {wdata[ADDR_W-9:0], base[7:0]};
      else       nxt = {base[ADDR_W-1:8], wdata};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         base   <= '0;
      end else begin
         if (act_we)         active <= wdata[0];
         if (hi_we || lo_we) base   <= nxt & KEEP;
      end
   end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
   import cfgp_pkg::*;
#(
   parameter int NUM_DEV  = 12,
   parameter int ADDR_W   = 12,
   parameter int ALIGN    = 3,
   parameter int WIDE_DEV = 11,
   parameter int PWR_DEV  = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_addr,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [7:0]                bus_wdata,
   output logic [7:0]                bus_rdata,
   output logic                      cfg_open,
   output logic [NUM_DEV-1:0]        dev_en,
   output logic [NUM_DEV*ADDR_W-1:0] dev_base,
   output logic                      i2c_sel,
   output logic [1:0]                pwr_mode
);
   localparam int LDN_W = $clog2(NUM_DEV);
   localparam logic [LDN_W-1:0] PWR_SEL = LDN_W'(PWR_DEV);

   if (NUM_DEV < 2 || NUM_DEV > 16 || PWR_DEV >= NUM_DEV || WIDE_DEV >= NUM_DEV ||
       ADDR_W < 9 || ADDR_W > 16 || ALIGN > 7) begin : g_bad_cfg
      $error("cfg_port_ctrl: unsupported parameter set");
   end

   logic             idx_wr, dat_wr, reg_wr;
   logic [7:0]       reg_idx;
   logic [LDN_W-1:0] ldn;
   logic             ldn_ok;
   logic [ADDR_W-1:0] base_arr [NUM_DEV];
   logic [ADDR_W-1:0] sel_base;
   logic              sel_act;

   assign idx_wr = bus_wr & ~bus_addr;
   assign dat_wr = bus_wr & bus_addr;
   assign reg_wr = dat_wr & cfg_open;
   assign ldn_ok = (int'(ldn) < NUM_DEV);

   cfgp_unlock u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr  (idx_wr),
      .dat_wr  (dat_wr),
      .wdata   (bus_wdata),
      .is_open (cfg_open),
      .reg_idx (reg_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ldn      <= '0;
         i2c_sel  <= 1'b0;
         pwr_mode <= 2'b00;
      end else if (reg_wr) begin
         if (reg_idx == REG_DEVSEL) ldn     <= bus_wdata[LDN_W-1:0];
         if (reg_idx == REG_PINMUX) i2c_sel <= bus_wdata[1];
         if (reg_idx == REG_PWRLOSS && ldn == PWR_SEL) pwr_mode <= bus_wdata[6:5];
      end
   end

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
      logic hit;
      assign hit = reg_wr && (ldn == LDN_W'(g));
      cfgp_bank #(
         .ADDR_W (ADDR_W),
         .ALIGN  (ALIGN),
         .WIDE   (g == WIDE_DEV)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .act_we (hit && reg_idx == REG_ACTIVE),
         .hi_we  (hit && reg_idx == REG_BASE_HI),
         .lo_we  (hit && reg_idx == REG_BASE_LO),
         .wdata  (bus_wdata),
         .active (dev_en[g]),
         .base   (base_arr[g])
      );
      assign dev_base[g*ADDR_W +: ADDR_W] = base_arr[g];
   end

   always_comb begin
      sel_base = '0;
      sel_act  = 1'b0;
      for (int i = 0; i < NUM_DEV; i++) begin
         if (ldn_ok && int'(ldn) == i) begin
            sel_base = base_arr[i];
            sel_act  = dev_en[i];
         end
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_rd) begin
         if (!cfg_open)     bus_rdata = 8'hFF;
         else if (!bus_addr) bus_rdata = reg_idx;
         else begin
            case (reg_idx)
               REG_DEVSEL:  bus_rdata = 8'(ldn);
               REG_PINMUX:  bus_rdata = {6'b0, i2c_sel, 1'b0};
               REG_ACTIVE:  bus_rdata = {7'b0, sel_act};
               REG_BASE_HI: bus_rdata = 8'(sel_base >> 8);
               REG_BASE_LO: bus_rdata = sel_base[7:0];
               REG_PWRLOSS: bus_rdata = (ldn == PWR_SEL) ? {1'b0, pwr_mode, 5'b0} : 8'h00;
               default:     bus_rdata = 8'h00;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
   parameter int NUM_DEV = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_addr,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic               cfg_open,
   input logic [NUM_DEV-1:0] dev_en,
   input logic               i2c_sel,
   input logic [1:0]         pwr_mode
);
   AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87)); // R2

   AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_open); // R4

   AST_SEALED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && bus_rd) |-> bus_rdata == 8'hFF); // R5

   AST_SEALED_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(dev_en)); // R5

   AST_PINMUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_open && bus_wr && bus_addr) |=> $stable(i2c_sel)); // R10

   AST_PWR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_open && bus_wr && bus_addr) |=> $stable(pwr_mode)); // R11
endmodule

bind cfg_port_ctrl cfgp_checker #(.NUM_DEV(NUM_DEV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .cfg_open  (cfg_open),
   .dev_en    (dev_en),
   .i2c_sel   (i2c_sel),
   .pwr_mode  (pwr_mode)
);

// File: tb/test_cfg_port_ctrl.sv
`timescale 1ns/1ps
module test_cfg_port_ctrl;
   localparam int ND = 12;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_addr = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_wdata = 8'h00;
   logic [7:0]    bus_rdata;
   logic          cfg_open;
   logic [ND-1:0] dev_en;
   logic [ND*AW-1:0] dev_base;
   logic          i2c_sel;
   logic [1:0]    pwr_mode;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_stage;
   int m_idx;
   int m_ldn;
   int m_act [ND];
   int m_base [ND];
   int m_i2c;
   int m_pwr;

   always #5 clk = ~clk;

   cfg_port_ctrl i_cfg_port_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cfg_open(cfg_open), .dev_en(dev_en), .dev_base(dev_base),
      .i2c_sel(i2c_sel), .pwr_mode(pwr_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int model_read(input int a);
      if (m_stage != 2) return 8'hFF;
      if (a == 0) return m_idx;
      case (m_idx)
         8'h07: return m_ldn;
         8'h2A: return m_i2c << 1;
         8'h30: return (m_ldn < ND) ? m_act[m_ldn] : 0;
         8'h60: return (m_ldn < ND) ? (m_base[m_ldn] >> 8) : 0;
         8'h61: return (m_ldn < ND) ? (m_base[m_ldn] & 8'hFF) : 0;
         8'hE4: return (m_ldn == 10) ? (m_pwr << 5) : 0;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stage = 0; m_idx = 0; m_ldn = 0; m_i2c = 0; m_pwr = 0;
         for (int i = 0; i < ND; i++) begin m_act[i] = 0; m_base[i] = 0; end
      end else if (bus_wr) begin
         int d;
         int msk;
         d = int'(bus_wdata);
         if (!bus_addr) begin
            if (m_stage == 0)      m_stage = (d == 8'h87) ? 1 : 0;
            else if (m_stage == 1) m_stage = (d == 8'h87) ? 2 : 0;
            else if (d == 8'hAA)   m_stage = 0;
            else                   m_idx = d;
         end else if (m_stage == 1) begin
            m_stage = 0;
         end else if (m_stage == 2) begin
            msk = (m_ldn == 11) ? 12'hFF8 : 12'h7F8;
            case (m_idx)
               8'h07: m_ldn = d & 15;
               8'h2A: m_i2c = (d >> 1) & 1;
               8'h30: if (m_ldn < ND) m_act[m_ldn] = d & 1;
               8'h60: if (m_ldn < ND) m_base[m_ldn] = (((d & 15) << 8) | (m_base[m_ldn] & 8'hFF)) & msk;
               8'h61: if (m_ldn < ND) m_base[m_ldn] = ((m_base[m_ldn] & 12'hF00) | d) & msk;
               8'hE4: if (m_ldn == 10) m_pwr = (d >> 5) & 3;
               default: ;
            endcase
         end
      end
   end

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 cfg_open", int'(cfg_open), (m_stage == 2) ? 1 : 0);
         chk("R10 i2c_sel", int'(i2c_sel), m_i2c);
         chk("R11 pwr_mode", int'(pwr_mode), m_pwr);
         for (int i = 0; i < ND; i++) begin
            chk("R9 dev_en", int'(dev_en[i]), m_act[i]);
            chk("R8 dev_base", int'(dev_base[i*AW +: AW]), m_base[i]);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, input string req, input int exp);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(req, int'(bus_rdata), exp);
      chk({req, " model"}, int'(bus_rdata), model_read(int'(a)));
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic setreg(input logic [7:0] r, input logic [7:0] d);
      wr(1'b0, r);
      wr(1'b1, d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 open", int'(cfg_open), 0);
      chk("R1 en", int'(dev_en), 0);
      chk("R1 base", int'(dev_base == '0), 1);
      chk("R1 i2c", int'(i2c_sel), 0);
      chk("R1 pwr", int'(pwr_mode), 0);
      rst_n = 1'b1;

      rd(1'b1, "R5 sealed data read", 8'hFF);
      rd(1'b0, "R5 sealed index read", 8'hFF);
      wr(1'b0, 8'h30);
      wr(1'b1, 8'h01);
      chk("R5 sealed write", int'(dev_en), 0);

      wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
      chk("R3 broken by index", int'(cfg_open), 0);
      wr(1'b1, 8'h00); wr(1'b0, 8'h87);
      chk("R3 broken by data", int'(cfg_open), 0);
      rd(1'b1, "R3 still sealed", 8'hFF);
      wr(1'b0, 8'h87);
      chk("R2 unlocked", int'(cfg_open), 1);
      rd(1'b0, "R6 index readback", 8'h00);

      setreg(8'h07, 8'h03);
      rd(1'b1, "R7 device select", 8'h03);
      setreg(8'h30, 8'hFF);
      chk("R9 activate", int'(dev_en), 12'h008);
      rd(1'b1, "R9 activate read", 8'h01);
      setreg(8'h60, 8'hFF);
      setreg(8'h61, 8'hFF);
      rd(1'b1, "R8 low byte", 8'hF8);
      chk("R8 narrow base", int'(dev_base[3*AW +: AW]), 12'h7F8);

      setreg(8'h07, 8'h0B);
      setreg(8'h60, 8'hFF);
      setreg(8'h61, 8'h0F);
      chk("R8 wide base", int'(dev_base[11*AW +: AW]), 12'hF08);
      wr(1'b0, 8'h60);
      rd(1'b1, "R8 wide high", 8'h0F);
      setreg(8'h07, 8'h03);
      wr(1'b0, 8'h60);
      rd(1'b1, "R7 bank 3 high", 8'h07);
      setreg(8'h07, 8'h00);
      wr(1'b0, 8'h60);
      rd(1'b1, "R7 bank 0 high", 8'h00);

      setreg(8'h2A, 8'hFF);
      chk("R10 pin select", int'(i2c_sel), 1);
      setreg(8'h07, 8'h02);
      wr(1'b0, 8'h2A);
      rd(1'b1, "R10 after device change", 8'h02);
      chk("R10 held", int'(i2c_sel), 1);

      setreg(8'hE4, 8'hFF);
      chk("R11 wrong device", int'(pwr_mode), 0);
      rd(1'b1, "R11 wrong device read", 8'h00);
      setreg(8'h07, 8'h0A);
      setreg(8'hE4, 8'hFF);
      chk("R11 set", int'(pwr_mode), 3);
      rd(1'b1, "R11 read", 8'h60);
      wr(1'b1, 8'h20);
      chk("R11 restore-on", int'(pwr_mode), 1);

      setreg(8'h55, 8'hFF);
      rd(1'b1, "R12 unlisted reg", 8'h00);
      setreg(8'h07, 8'h0F);
      setreg(8'h30, 8'h01);
      rd(1'b1, "R7 out of range bank", 8'h00);
      chk("R7 out of range write", int'(dev_en), 12'h008);

      wr(1'b0, 8'hAA);
      chk("R4 sealed again", int'(cfg_open), 0);
      rd(1'b1, "R5 sealed after close", 8'hFF);
      wr(1'b1, 8'h00);
      chk("R5 write after close", int'(i2c_sel), 1);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule